// File: doc/BRIEF.md
# Wave-Addressed Shared Packet Buffer

This block is the central packet store of an eight-input, eight-output switch. Every input writes into one common memory and every output reads from it. No per-port buffers exist. The memory is split into eight banks of 256 rows by 32 bits, which gives 64 Kbit in total. A packet is always eight words long and owns one slot index, which names the same row in every bank. Word k of a packet always lives in bank k.

An access enters bank 0 in the cycle it is granted. Its slot, direction and port number then move one bank further on each clock, so bank k serves that access k cycles after the grant. A single round-robin arbiter admits at most one new access per cycle. It chooses among the input write requests and the output read requests. Because consecutive accesses are always one bank apart, they never collide.

A write takes its slot from a free list. At grant time the slot is appended to the queue of the packet's destination output. A read takes the slot at the head of its output's queue. The slot goes back to the free list as the read finishes in the last bank. A read may be granted in the cycle right after the write of the same packet. This is cut-through: the read wave trails the write wave by one bank, so the packet starts leaving while its later words are still being written.

Top module: `shared_pkt_buf`

## Requirements
- R1: After reset no write or read grant is issued for idle requests, `rdValid` is all zero, and the free list holds all 256 slots.
- R2: At most one grant per cycle is issued across all of `wrGnt` and `rdGnt` together. It goes only to a port whose request is high in that cycle. The grant is combinational with the request.
- R3: When input i is granted in cycle t, word k of its packet is taken from `wrData[32*i +: 32]` in cycle t+k, for k = 0..7. Word 0 is on that bus in the grant cycle. The destination output is taken from `wrDest[3*i +: 3]` in cycle t.
- R4: When output o is granted a read in cycle t, word k of the packet is on `rdData[32*o +: 32]` with `rdValid[o]` high in cycle t+k+1, for k = 0..7.
- R5: Each output delivers the packets addressed to it in the order in which their writes were granted, and every word matches the word that was written.
- R6: A read for output o can be granted in the cycle right after a write to o was granted into an empty queue, before the packet's last word has been written. The packet still reads back correctly.
- R7: A read request is ignored while its output's queue is empty: no grant is issued and no slot is consumed.
- R8: When all 256 slots hold unread packets, write requests are refused and stay pending. A pending write can be granted no earlier than 8 cycles after a read grant, and is then granted exactly 8 cycles after it if no other request competes.
- R9: Arbitration is round robin over 16 requesters: writes of inputs 0..7, then reads of outputs 0..7. The requester granted in a cycle has the lowest priority in the next cycle. If all eight inputs request together, they are granted on eight consecutive cycles in ascending cyclic port order.
- R10: An input is not granted again until 8 cycles after its previous write grant, and an output is not granted again until 8 cycles after its previous read grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrReq | input | 8 | Write request per input port |
| wrDest | input | 24 | Destination output per input, 3 bits each, sampled at grant |
| wrData | input | 256 | Word stream per input, 32 bits each |
| wrGnt | output | 8 | Write grant per input, combinational |
| rdReq | input | 8 | Read request per output port |
| rdGnt | output | 8 | Read grant per output, combinational |
| rdValid | output | 8 | Read word valid per output |
| rdData | output | 256 | Read word per output, 32 bits each |

## Verification
Grants are combinational, so the bench drives its requests on the falling edge and reads `wrGnt` and `rdGnt` 1 ns later in the same cycle. It stamps every grant with a cycle count. Written words are due on the input bus k cycles after a write grant, and read words are due on the output k+1 cycles after a read grant. The monitor compares both the value and the arrival cycle of every word against the stamp. A returned slot becomes usable 8 cycles after the read grant, and the full-buffer check compares the refused write's grant cycle with exactly that offset.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int NPORT = 8;
  localparam int NBANK = 8;
  localparam int DEPTH = 256;
  localparam int WIDTH = 32;
  localparam int PW    = $clog2(NPORT);
  localparam int SW    = $clog2(DEPTH);
  localparam int CW    = SW + 1;
  localparam int NREQ  = 2 * NPORT;
  localparam int IW    = $clog2(NREQ);
  localparam int GW    = $clog2(NBANK) + 1;

  // one bank stage of the access wave
  typedef struct packed {
    logic          vld;
    logic          wr;
    logic [SW-1:0] slot;
    logic [PW-1:0] port;
  } stage_t;
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      wrReq,
  input  logic [NPORT*PW-1:0]   wrDest,
  input  logic [NPORT-1:0]      rdReq,
  output logic [NPORT-1:0]      wrGnt,
  output logic [NPORT-1:0]      rdGnt,
  output stage_t [NBANK-1:0]    stg
);
  stage_t [NBANK-2:0] pipeQ;
  stage_t             entry;
  logic [NPORT-1:0]   inBusy, outBusy;
  logic [NREQ-1:0]    elig, gnt;
  logic [IW-1:0]      rrPtr, winIdx;
  logic               found, isWr;
  logic [PW-1:0]      winPort, destSel;

  // free list: never-used counter plus recycle ring
  logic [CW-1:0] freshCnt, recCnt;
  logic [SW-1:0] recRd, recWr;
  logic [SW-1:0] recMem [DEPTH];
  logic          freshLeft, freeAvail, relVld;
  logic [SW-1:0] allocSlot, relSlot;

  // per-output slot queues as linked lists
  logic [SW-1:0] head [NPORT];
  logic [SW-1:0] tail [NPORT];
  logic [CW-1:0] qCnt [NPORT];
  logic [SW-1:0] nextPtr [DEPTH];

  assign stg = {pipeQ, entry};

  always_comb begin
    inBusy  = '0;
    outBusy = '0;
    for (int k = 0; k < NBANK-1; k++) begin
      if (pipeQ[k].vld) begin
        if (pipeQ[k].wr) inBusy[pipeQ[k].port]  = 1'b1;
        else             outBusy[pipeQ[k].port] = 1'b1;
      end
    end
  end

  assign freshLeft = (freshCnt != CW'(DEPTH));
  assign freeAvail = freshLeft || (recCnt != '0);
  assign allocSlot = freshLeft ? freshCnt[SW-1:0] : recMem[recRd];
  assign relVld    = pipeQ[NBANK-2].vld && !pipeQ[NBANK-2].wr;
  assign relSlot   = pipeQ[NBANK-2].slot;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      elig[p]         = wrReq[p] && !inBusy[p] && freeAvail;
      elig[NPORT + p] = rdReq[p] && !outBusy[p] && (qCnt[p] != '0);
    end
  end

  // rotating-priority search starting at rrPtr
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NREQ; i++) begin
      int cand;
      cand = (int'(rrPtr) + i) % NREQ;
      if (!found && elig[cand]) begin
        found  = 1'b1;
        winIdx = IW'(cand);
      end
    end
  end

  assign gnt     = found ? (NREQ'(1) << winIdx) : '0;
  assign wrGnt   = gnt[NPORT-1:0];
  assign rdGnt   = gnt[NREQ-1:NPORT];
  assign isWr    = found && (winIdx < IW'(NPORT));
  assign winPort = winIdx[PW-1:0];
  assign destSel = wrDest[int'(winPort)*PW +: PW];

  always_comb begin
    entry.vld  = found;
    entry.wr   = isWr;
    entry.port = winPort;
    entry.slot = isWr ? allocSlot : head[winPort];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipeQ    <= '0;
      rrPtr    <= '0;
      freshCnt <= '0;
      recCnt   <= '0;
      recRd    <= '0;
      recWr    <= '0;
      for (int p = 0; p < NPORT; p++) begin
        head[p] <= '0;
        tail[p] <= '0;
        qCnt[p] <= '0;
      end
    end else begin
      pipeQ <= {pipeQ[NBANK-3:0], entry};
      if (found) rrPtr <= (winIdx == IW'(NREQ-1)) ? '0 : winIdx + 1'b1;
      if (isWr && freshLeft)  freshCnt <= freshCnt + 1'b1;
      if (isWr && !freshLeft) recRd    <= recRd + 1'b1;
      if (relVld)             recWr    <= recWr + 1'b1;
      recCnt <= recCnt + CW'(relVld) - CW'(isWr && !freshLeft);
      for (int p = 0; p < NPORT; p++) begin
        if (isWr && destSel == PW'(p)) begin
          if (qCnt[p] == '0) head[p] <= entry.slot;
          tail[p] <= entry.slot;
          qCnt[p] <= qCnt[p] + 1'b1;
        end else if (found && !isWr && winPort == PW'(p)) begin
          head[p] <= nextPtr[head[p]];
          qCnt[p] <= qCnt[p] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (isWr && qCnt[destSel] != '0) nextPtr[tail[destSel]] <= entry.slot;
    if (relVld) recMem[recWr] <= relSlot;
  end

  // R2: one access enters bank 0 per cycle
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdGnt, wrGnt}));

  // R8: recycled slots never outnumber handed-out slots
  p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recCnt <= freshCnt);

  // R8: no write admitted with every slot occupied
  p_refuse_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freshCnt == CW'(DEPTH) && recCnt == '0) |-> (wrGnt == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   gap <= '0;
      else if (wrGnt[p])                            gap <= GW'(1);
      else if (gap != '0 && gap < GW'(NBANK))       gap <= gap + 1'b1;
    end
    // R10: an input's stream is never overlapped by a new grant
    p_in_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wrGnt[p] |-> (gap == '0 || gap == GW'(NBANK)));
    // R7: reads only ever take from a non-empty queue
    p_rd_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdGnt[p] |-> (qCnt[p] != '0));
  end
endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  stage_t [NBANK-1:0]     stg,
  input  logic [NPORT*WIDTH-1:0] wrData,
  output logic [NPORT-1:0]       rdValid,
  output logic [NPORT*WIDTH-1:0] rdData
);
  logic [NBANK-1:0][WIDTH-1:0] bankQ;
  logic [NBANK-1:0]            outVld;
  logic [NBANK-1:0][PW-1:0]    outPort;
  logic [NPORT-1:0][NBANK-1:0] hitMat;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic [WIDTH-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (stg[k].vld && stg[k].wr)
        mem[stg[k].slot] <= wrData[int'(stg[k].port)*WIDTH +: WIDTH];
      if (stg[k].vld && !stg[k].wr)
        bankQ[k] <= mem[stg[k].slot];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        outVld[k]  <= 1'b0;
        outPort[k] <= '0;
      end else begin
        outVld[k]  <= stg[k].vld && !stg[k].wr;
        outPort[k] <= stg[k].port;
      end
    end
  end

  always_comb begin
    rdValid = '0;
    rdData  = '0;
    hitMat  = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int k = 0; k < NBANK; k++) begin
        if (outVld[k] && outPort[k] == PW'(o)) begin
          hitMat[o][k]                = 1'b1;
          rdValid[o]                  = 1'b1;
          rdData[o*WIDTH +: WIDTH]    = bankQ[k];
        end
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R4: one bank feeds each output per cycle
    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hitMat[o]) <= 1);
  end
endmodule

// File: rtl/shared_pkt_buf.sv
module shared_pkt_buf
  import sbuf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       wrReq,
  input  logic [NPORT*PW-1:0]    wrDest,
  input  logic [NPORT*WIDTH-1:0] wrData,
  output logic [NPORT-1:0]       wrGnt,
  input  logic [NPORT-1:0]       rdReq,
  output logic [NPORT-1:0]       rdGnt,
  output logic [NPORT-1:0]       rdValid,
  output logic [NPORT*WIDTH-1:0] rdData
);
  stage_t [NBANK-1:0] stg;

  sbuf_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wrReq (wrReq),
    .wrDest(wrDest),
    .rdReq (rdReq),
    .wrGnt (wrGnt),
    .rdGnt (rdGnt),
    .stg   (stg)
  );

  sbuf_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stg    (stg),
    .wrData (wrData),
    .rdValid(rdValid),
    .rdData (rdData)
  );
endmodule

// File: tb/shared_pkt_buf_tb.sv
module shared_pkt_buf_tb;
  import sbuf_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n;
  logic [NPORT-1:0]       wrReq, wrGnt, rdReq, rdGnt, rdValid;
  logic [NPORT*PW-1:0]    wrDest;
  logic [NPORT*WIDTH-1:0] wrData, rdData;

  shared_pkt_buf u_dut (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrDest(wrDest), .wrData(wrData),
    .wrGnt(wrGnt), .rdReq(rdReq), .rdGnt(rdGnt), .rdValid(rdValid), .rdData(rdData)
  );

  int vecs = 0, errs = 0, cyc = 0, totalWr = 0;
  bit done = 0, randMode = 0;
  int pend [NPORT][$];
  int act [NPORT][$];
  int actStart [NPORT][$];
  int outK [NPORT], inK [NPORT], inId [NPORT], seq [NPORT];
  int want [NPORT], nextDest [NPORT], rdLeft [NPORT];
  int lastRd [NPORT], lastWrCyc [NPORT];
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] word(int id, int k);
    return 32'(id * 8 + k) ^ 32'h5A00_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act_v, longint exp_v);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act_v, exp_v, cyc);
    end
  endtask

  task automatic step();
    bit busy [NPORT];
    @(negedge clk);
    // monitor: every delivered word against scoreboard
    for (int o = 0; o < NPORT; o++) begin
      if (rdValid[o]) begin
        if (act[o].size() == 0) chk(0, "R5", "word with no read pending", o, -1);
        else begin
          chk(rdData[o*WIDTH +: WIDTH] == word(act[o][0], outK[o]), "R3", "read word value",
              rdData[o*WIDTH +: WIDTH], word(act[o][0], outK[o]));
          chk(cyc == actStart[o][0] + outK[o] + 1, "R4", "read word cycle",
              cyc, actStart[o][0] + outK[o] + 1);
          outK[o]++;
          if (outK[o] == NBANK) begin
            void'(act[o].pop_front());
            void'(actStart[o].pop_front());
            outK[o] = 0;
          end
        end
      end else if (act[o].size() != 0 && cyc == actStart[o][0] + outK[o] + 1) begin
        chk(0, "R4", "rdValid missing", 0, 1);
      end
    end
    // drive inputs
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    for (int i = 0; i < NPORT; i++) begin
      busy[i] = (inK[i] != 0);
      if (inK[i] != 0) begin
        wrData[i*WIDTH +: WIDTH] = word(inId[i], inK[i]);
        inK[i] = (inK[i] == NBANK-1) ? 0 : inK[i] + 1;
      end else begin
        wrData[i*WIDTH +: WIDTH] = word(i*65536 + seq[i], 0);
      end
      wrReq[i] = (want[i] > 0) && (!randMode || rng[i]);
      wrDest[i*PW +: PW] = PW'(nextDest[i]);
    end
    for (int o = 0; o < NPORT; o++) rdReq[o] = (rdLeft[o] > 0);
    #1;
    chk($onehot0({rdGnt, wrGnt}), "R2", "grants not one-hot", {rdGnt, wrGnt}, 0);
    for (int i = 0; i < NPORT; i++) begin
      if (wrGnt[i]) begin
        chk(wrReq[i], "R2", "write grant without request", 0, 1);
        chk(!busy[i], "R10", "write grant during own stream", 1, 0);
        inId[i] = i*65536 + seq[i];
        seq[i]++;
        pend[nextDest[i]].push_back(inId[i]);
        inK[i] = 1;
        want[i]--;
        lastWrCyc[i] = cyc;
        totalWr++;
        if (randMode) nextDest[i] = int'(rng[10:8] ^ 3'(i));
      end
    end
    for (int o = 0; o < NPORT; o++) begin
      if (rdReq[o] && pend[o].size() == 0)
        chk(!rdGnt[o], "R7", "read granted on empty queue", rdGnt[o], 0);
      if (rdGnt[o] && pend[o].size() != 0) begin
        chk(cyc - lastRd[o] >= NBANK, "R10", "read grant spacing", cyc - lastRd[o], NBANK);
        act[o].push_back(pend[o].pop_front());
        actStart[o].push_back(cyc);
        lastRd[o] = cyc;
        rdLeft[o]--;
      end
    end
    cyc++;
  endtask

  function automatic bit quiet();
    for (int p = 0; p < NPORT; p++)
      if (pend[p].size() != 0 || act[p].size() != 0 || inK[p] != 0 || want[p] != 0) return 0;
    return 1;
  endfunction

  task automatic drain();
    while (!quiet()) begin
      for (int o = 0; o < NPORT; o++) rdLeft[o] = pend[o].size();
      step();
    end
    for (int o = 0; o < NPORT; o++) rdLeft[o] = 0;
  endtask

  initial begin
    int base, g, s, mn;
    rst_n = 1'b0;
    wrReq = '0; rdReq = '0; wrDest = '0; wrData = '0;
    for (int p = 0; p < NPORT; p++) lastRd[p] = -100;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: idle after reset
    chk(wrGnt == '0, "R1", "wrGnt after reset", wrGnt, 0);
    chk(rdGnt == '0, "R1", "rdGnt after reset", rdGnt, 0);
    chk(rdValid == '0, "R1", "rdValid after reset", rdValid, 0);

    // R6: cut-through read one cycle behind the write
    want[2] = 1; nextDest[2] = 5; rdLeft[5] = 1;
    repeat (4) step();
    chk(lastRd[5] == lastWrCyc[2] + 1, "R6", "cut-through read grant cycle", lastRd[5], lastWrCyc[2] + 1);
    drain();

    // R7: reads of an empty queue ignored
    rdLeft[3] = 4;
    repeat (12) step();
    chk(rdLeft[3] == 4, "R7", "reads consumed from empty queue", 4 - rdLeft[3], 0);
    rdLeft[3] = 0;

    // R9: all inputs request together
    base = totalWr;
    for (int i = 0; i < NPORT; i++) begin want[i] = 1; nextDest[i] = NPORT-1-i; end
    while (totalWr < base + NPORT) step();
    mn = lastWrCyc[0]; s = 0;
    for (int i = 1; i < NPORT; i++) if (lastWrCyc[i] < mn) begin mn = lastWrCyc[i]; s = i; end
    for (int j = 0; j < NPORT; j++)
      chk(lastWrCyc[(s+j)%NPORT] == mn + j, "R9", "round-robin grant cycle",
          lastWrCyc[(s+j)%NPORT], mn + j);
    drain();

    // R8 / R1: fill all 256 slots, then one more write
    base = totalWr;
    for (int i = 0; i < NPORT; i++) begin want[i] = DEPTH/NPORT; nextDest[i] = i; end
    while (totalWr < base + DEPTH) step();
    chk(totalWr - base == DEPTH, "R1", "slots accepted before full", totalWr - base, DEPTH);
    want[0] = 1; nextDest[0] = 0;
    repeat (16) step();
    chk(want[0] == 1, "R8", "write accepted while full", 1 - want[0], 0);
    rdLeft[4] = 1;
    while (rdLeft[4] > 0) step();
    g = lastRd[4];
    while (want[0] > 0) step();
    chk(lastWrCyc[0] == g + NBANK, "R8", "write grant after slot return", lastWrCyc[0], g + NBANK);
    drain();

    // R5 / R10: random mixed traffic with reads held high
    randMode = 1;
    for (int i = 0; i < NPORT; i++) begin want[i] = 25; nextDest[i] = (i * 3) % NPORT; end
    while (!quiet()) begin
      for (int o = 0; o < NPORT; o++) rdLeft[o] = 1000;
      step();
    end
    for (int o = 0; o < NPORT; o++) rdLeft[o] = 0;
    randMode = 0;
    repeat (4) step();
    chk(rdValid == '0, "R5", "stray output after drain", rdValid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule